// File: doc/BRIEF.md
# Interrupt Trigger and End-of-Interrupt Engine

This block is the per-pin acceptance stage of an I/O interrupt controller. Each cycle it samples the raw interrupt pins. It applies each pin's polarity and keeps two state bits per pin: a pending bit that follows the effective level, and a remote-pending bit that is set while a level-triggered interrupt waits for the processor's end-of-interrupt. From these bits it decides when a pin needs service. It then builds one delivery message at a time from that pin's redirection entry and holds the message on a valid/accepted handshake until the downstream side takes it.

The engine also takes end-of-interrupt messages. Each one carries a vector and a trigger type. A 256-entry vector-in-use map is rebuilt from all entries when the register block pulses its table-update strobe, and this map screens out stray end-of-interrupts. Every pin whose programmed vector matches gets a one-cycle acknowledge pulse. A level-type end-of-interrupt also clears the remote-pending bit, so a pin that is still asserted is delivered again. The redirection entries come in as flat per-field vectors. The pending and remote-pending vectors are brought out as status.

Top module: `trig_eoi_engine`

## Requirements
- R1: The effective level of pin i is pinRaw[i] XOR entPolarity[i]. A polarity bit of 1 makes a low pin active.
- R2: pendingVec[i] equals the effective level sampled at the previous clock edge. It is set when the level is high and cleared when it is low.
- R3: An edge-triggered pin (entTrigLevel[i]=0) asks for one delivery for each 0→1 change of its pending bit, and holding the level high asks for nothing more. If the pending bit rises again while the earlier request has not yet been accepted, coalesced[i] pulses for one cycle and no extra delivery follows.
- R4: A level-triggered pin (entTrigLevel[i]=1) asks for delivery while pending is set and remoteIrrVec[i] is clear. Acceptance of its message sets remoteIrrVec[i], and no further delivery follows while it stays set. A rise of pending while remoteIrrVec[i] is set pulses coalesced[i].
- R5: A pin whose entMask[i] is 1 in the cycle before a message would be issued is never delivered.
- R6: A message copies destination, vector, destination mode, delivery mode and trigger mode from the granted pin's entry, with dlvAssert=1 and dlvShorthand=0. dlvValid rises one edge after the edge at which the request arises. The payload holds steady until the edge at which dlvAccept is high, and dlvValid is low in the cycle after that edge.
- R7: A message for pin 0 always carries dlvDestMode=0 (physical) and dlvDest=bootCpuId, whatever its entry holds.
- R8: When several pins ask at once, the lowest pin number is granted first. Only one message is issued at a time, and the next one can appear no earlier than one cycle after the previous is accepted.
- R9: The vector-in-use map is rebuilt from all entVector fields at each edge where tblUpdate is 1 and is cleared by reset. An end-of-interrupt whose vector is not in the map has no effect: no acknowledge and no remote-pending change.
- R10: An end-of-interrupt accepted at an edge (eoiValid=1, vector in the map) drives ackPulse[i]=1 for exactly the next cycle, for every pin i whose entVector equals eoiVector, whether masked or not.
- R11: A level-type end-of-interrupt (eoiLevel=1) clears remoteIrrVec for every matching pin at the same edge, and a matching pin that is unmasked and still pending is delivered again. An edge-type one (eoiLevel=0) leaves remoteIrrVec unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinRaw | input | NUM_PINS | Raw interrupt pin levels |
| entVector | input | NUM_PINS*8 | Vector field of each entry, pin i at bits [8i+7:8i] |
| entDest | input | NUM_PINS*DEST_W | Destination ID of each entry |
| entDestMode | input | NUM_PINS | Destination mode per entry (0 physical, 1 logical) |
| entDelivMode | input | NUM_PINS*3 | Delivery mode per entry |
| entTrigLevel | input | NUM_PINS | 1 level-triggered, 0 edge-triggered |
| entPolarity | input | NUM_PINS | 1 active-low |
| entMask | input | NUM_PINS | 1 masked |
| tblUpdate | input | 1 | Entry table was written or reloaded; rebuild vector map |
| bootCpuId | input | DEST_W | Fixed destination used for pin 0 |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | 8 | End-of-interrupt vector |
| eoiLevel | input | 1 | End-of-interrupt is level-type |
| dlvAccept | input | 1 | Downstream takes the current message |
| dlvValid | output | 1 | Message valid |
| dlvPin | output | PIN_W | Pin that produced the message |
| dlvDest | output | DEST_W | Message destination |
| dlvVector | output | 8 | Message vector |
| dlvDestMode | output | 1 | Message destination mode |
| dlvDelivMode | output | 3 | Message delivery mode |
| dlvTrigLevel | output | 1 | Message trigger mode |
| dlvAssert | output | 1 | Level flag, always 1 |
| dlvShorthand | output | 2 | Destination shorthand, always 0 |
| ackPulse | output | NUM_PINS | Per-pin acknowledge pulse |
| coalesced | output | NUM_PINS | Per-pin coalesced-event pulse |
| pendingVec | output | NUM_PINS | Pending bits |
| remoteIrrVec | output | NUM_PINS | Remote-pending bits |

## Verification
A pin change applied before edge k shows in pendingVec and coalesced just after edge k. The resulting message shows after edge k+1. Acceptance at an edge drops dlvValid and sets the remote-pending bit right after that edge. An end-of-interrupt at an edge gives its acknowledge and its remote-pending clear just after that edge, and the redelivery one edge later. The bench drives every input one time unit after a rising edge and checks after exactly the number of single-edge steps given here. No check waits for an output to appear, so a result that comes a cycle early or late is reported.

// File: rtl/trig_eoi_pkg.sv
package trig_eoi_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int DMODE_W = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMsg;   // capture the granted entry into the message register
    logic retireMsg; // current message accepted downstream
  } ctrlStrobe_t;
endpackage

// File: rtl/trig_eoi_ctrl.sv
module trig_eoi_ctrl
  import trig_eoi_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinRaw,
  input  logic [NUM_PINS-1:0] entPolarity,
  input  logic [NUM_PINS-1:0] entMask,
  input  logic [NUM_PINS-1:0] entTrigLevel,
  input  logic [NUM_PINS-1:0] eoiClear,
  input  logic                msgValid,
  input  logic [PIN_W-1:0]    msgPin,
  input  logic                msgTrigLevel,
  input  logic                dlvAccept,
  output ctrlStrobe_t         strobe,
  output logic [PIN_W-1:0]    grantIdx,
  output logic [NUM_PINS-1:0] pendingVec,
  output logic [NUM_PINS-1:0] remoteIrrVec,
  output logic [NUM_PINS-1:0] coalesced
);
  logic [NUM_PINS-1:0] effLevel, riseVec, edgeReq, needSvc, takenOh;
  logic                taken, anyNeed;

  assign effLevel = pinRaw ^ entPolarity;
  assign riseVec  = effLevel & ~pendingVec;
  assign taken    = msgValid & dlvAccept;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++)
      takenOh[i] = taken && (msgPin == PIN_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendingVec <= '0;
    else       pendingVec <= effLevel;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    always_ff @(posedge clk) begin
      if (!rstN) begin
        edgeReq[g]      <= 1'b0;
        remoteIrrVec[g] <= 1'b0;
        coalesced[g]    <= 1'b0;
      end else begin
        // edge request latch
        if (entTrigLevel[g])
          edgeReq[g] <= 1'b0;
        else if (riseVec[g] && !entMask[g] && !edgeReq[g])
          edgeReq[g] <= 1'b1;
        else if (takenOh[g])
          edgeReq[g] <= 1'b0;
        // remote pending: acceptance wins over a same-cycle clear
        if (takenOh[g] && msgTrigLevel)
          remoteIrrVec[g] <= 1'b1;
        else if (eoiClear[g])
          remoteIrrVec[g] <= 1'b0;
        coalesced[g] <= riseVec[g] &&
                        (entTrigLevel[g] ? remoteIrrVec[g] : edgeReq[g]);
      end
    end

    assign needSvc[g] = !entMask[g] &&
                        (entTrigLevel[g] ? (pendingVec[g] && !remoteIrrVec[g])
                                         : edgeReq[g]);
  end

  // fixed priority, lowest pin first
  always_comb begin
    grantIdx = '0;
    anyNeed  = 1'b0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (needSvc[i]) begin
        grantIdx = PIN_W'(i);
        anyNeed  = 1'b1;
      end
    end
  end

  assign strobe.loadMsg   = anyNeed && !msgValid;
  assign strobe.retireMsg = taken;
endmodule

// File: rtl/trig_eoi_dp.sv
module trig_eoi_dp
  import trig_eoi_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DEST_W   = 8,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PINS*VEC_W-1:0]    entVector,
  input  logic [NUM_PINS*DEST_W-1:0]   entDest,
  input  logic [NUM_PINS-1:0]          entDestMode,
  input  logic [NUM_PINS*DMODE_W-1:0]  entDelivMode,
  input  logic [NUM_PINS-1:0]          entTrigLevel,
  input  logic                         tblUpdate,
  input  logic [DEST_W-1:0]            bootCpuId,
  input  logic                         eoiValid,
  input  logic [VEC_W-1:0]             eoiVector,
  input  logic                         eoiLevel,
  input  ctrlStrobe_t                  strobe,
  input  logic [PIN_W-1:0]             grantIdx,
  output logic [NUM_PINS-1:0]          eoiClear,
  output logic [NUM_PINS-1:0]          ackPulse,
  output logic                         msgValid,
  output logic [PIN_W-1:0]             msgPin,
  output logic [DEST_W-1:0]            msgDest,
  output logic [VEC_W-1:0]             msgVector,
  output logic                         msgDestMode,
  output logic [DMODE_W-1:0]           msgDelivMode,
  output logic                         msgTrigLevel
);
  logic [NUM_VEC-1:0]  vecMap, vecMapNext;
  logic [NUM_PINS-1:0] eoiMatch;
  logic                eoiHit;

  always_comb begin
    vecMapNext = '0;
    for (int i = 0; i < NUM_PINS; i++)
      vecMapNext[entVector[i*VEC_W +: VEC_W]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          vecMap <= '0;
    else if (tblUpdate) vecMap <= vecMapNext;
  end

  assign eoiHit = eoiValid && vecMap[eoiVector];

  for (genvar g = 0; g < NUM_PINS; g++) begin : gMatch
    assign eoiMatch[g] = eoiHit && (entVector[g*VEC_W +: VEC_W] == eoiVector);
  end

  assign eoiClear = eoiMatch & {NUM_PINS{eoiLevel}};

  always_ff @(posedge clk) begin
    if (!rstN) ackPulse <= '0;
    else       ackPulse <= eoiMatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid     <= 1'b0;
      msgPin       <= '0;
      msgDest      <= '0;
      msgVector    <= '0;
      msgDestMode  <= 1'b0;
      msgDelivMode <= '0;
      msgTrigLevel <= 1'b0;
    end else if (strobe.loadMsg) begin
      msgValid     <= 1'b1;
      msgPin       <= grantIdx;
      msgVector    <= entVector[grantIdx*VEC_W +: VEC_W];
      msgDelivMode <= entDelivMode[grantIdx*DMODE_W +: DMODE_W];
      msgTrigLevel <= entTrigLevel[grantIdx];
      if (grantIdx == '0) begin
        msgDest     <= bootCpuId;
        msgDestMode <= 1'b0;
      end else begin
        msgDest     <= entDest[grantIdx*DEST_W +: DEST_W];
        msgDestMode <= entDestMode[grantIdx];
      end
    end else if (strobe.retireMsg) begin
      msgValid <= 1'b0;
    end
  end
endmodule

// File: rtl/trig_eoi_engine.sv
module trig_eoi_engine
  import trig_eoi_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DEST_W   = 8,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PINS-1:0]          pinRaw,
  input  logic [NUM_PINS*VEC_W-1:0]    entVector,
  input  logic [NUM_PINS*DEST_W-1:0]   entDest,
  input  logic [NUM_PINS-1:0]          entDestMode,
  input  logic [NUM_PINS*DMODE_W-1:0]  entDelivMode,
  input  logic [NUM_PINS-1:0]          entTrigLevel,
  input  logic [NUM_PINS-1:0]          entPolarity,
  input  logic [NUM_PINS-1:0]          entMask,
  input  logic                         tblUpdate,
  input  logic [DEST_W-1:0]            bootCpuId,
  input  logic                         eoiValid,
  input  logic [VEC_W-1:0]             eoiVector,
  input  logic                         eoiLevel,
  input  logic                         dlvAccept,
  output logic                         dlvValid,
  output logic [PIN_W-1:0]             dlvPin,
  output logic [DEST_W-1:0]            dlvDest,
  output logic [VEC_W-1:0]             dlvVector,
  output logic                         dlvDestMode,
  output logic [DMODE_W-1:0]           dlvDelivMode,
  output logic                         dlvTrigLevel,
  output logic                         dlvAssert,
  output logic [1:0]                   dlvShorthand,
  output logic [NUM_PINS-1:0]          ackPulse,
  output logic [NUM_PINS-1:0]          coalesced,
  output logic [NUM_PINS-1:0]          pendingVec,
  output logic [NUM_PINS-1:0]          remoteIrrVec
);
  ctrlStrobe_t         strobe;
  logic [PIN_W-1:0]    grantIdx;
  logic [NUM_PINS-1:0] eoiClear;

  trig_eoi_ctrl #(.NUM_PINS(NUM_PINS)) uCtrl (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .entPolarity(entPolarity),
    .entMask(entMask), .entTrigLevel(entTrigLevel), .eoiClear(eoiClear),
    .msgValid(dlvValid), .msgPin(dlvPin), .msgTrigLevel(dlvTrigLevel),
    .dlvAccept(dlvAccept), .strobe(strobe), .grantIdx(grantIdx),
    .pendingVec(pendingVec), .remoteIrrVec(remoteIrrVec), .coalesced(coalesced)
  );

  trig_eoi_dp #(.NUM_PINS(NUM_PINS), .DEST_W(DEST_W)) uDp (
    .clk(clk), .rstN(rstN), .entVector(entVector), .entDest(entDest),
    .entDestMode(entDestMode), .entDelivMode(entDelivMode),
    .entTrigLevel(entTrigLevel), .tblUpdate(tblUpdate), .bootCpuId(bootCpuId),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .eoiLevel(eoiLevel),
    .strobe(strobe), .grantIdx(grantIdx), .eoiClear(eoiClear),
    .ackPulse(ackPulse), .msgValid(dlvValid), .msgPin(dlvPin),
    .msgDest(dlvDest), .msgVector(dlvVector), .msgDestMode(dlvDestMode),
    .msgDelivMode(dlvDelivMode), .msgTrigLevel(dlvTrigLevel)
  );

  assign dlvAssert    = 1'b1;
  assign dlvShorthand = 2'b00;
endmodule

// File: rtl/trig_eoi_engine_chk.sv
module trig_eoi_engine_chk #(
  parameter int NUM_PINS = 8,
  parameter int DEST_W   = 8,
  parameter int PIN_W    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] entMask,
  input logic [DEST_W-1:0]   bootCpuId,
  input logic                eoiValid,
  input logic                dlvAccept,
  input logic                dlvValid,
  input logic [PIN_W-1:0]    dlvPin,
  input logic [DEST_W-1:0]   dlvDest,
  input logic [7:0]          dlvVector,
  input logic                dlvDestMode,
  input logic [2:0]          dlvDelivMode,
  input logic                dlvTrigLevel,
  input logic [NUM_PINS-1:0] ackPulse,
  input logic [NUM_PINS-1:0] remoteIrrVec
);
  logic [NUM_PINS-1:0] maskPrev;
  always_ff @(posedge clk) maskPrev <= entMask;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid && !dlvAccept |=> dlvValid && $stable(dlvPin) && $stable(dlvDest) &&
      $stable(dlvVector) && $stable(dlvDestMode) && $stable(dlvDelivMode) &&
      $stable(dlvTrigLevel));

  p_remote_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid && dlvAccept && dlvTrigLevel |=> remoteIrrVec[$past(dlvPin)]);

  p_masked_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dlvValid) |-> !maskPrev[dlvPin]);

  p_pin0_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dlvValid) && dlvPin == '0 |-> !dlvDestMode && dlvDest == $past(bootCpuId));

  p_ack_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|ackPulse) |-> $past(eoiValid));
endmodule

bind trig_eoi_engine trig_eoi_engine_chk #(
  .NUM_PINS(NUM_PINS), .DEST_W(DEST_W), .PIN_W(PIN_W)
) uChk (
  .clk(clk), .rstN(rstN), .entMask(entMask), .bootCpuId(bootCpuId),
  .eoiValid(eoiValid), .dlvAccept(dlvAccept), .dlvValid(dlvValid),
  .dlvPin(dlvPin), .dlvDest(dlvDest), .dlvVector(dlvVector),
  .dlvDestMode(dlvDestMode), .dlvDelivMode(dlvDelivMode),
  .dlvTrigLevel(dlvTrigLevel), .ackPulse(ackPulse), .remoteIrrVec(remoteIrrVec)
);

// File: tb/trig_eoi_engine_test.sv
`timescale 1ns/1ps
module trig_eoi_engine_test;
  localparam int NP = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  logic [NP-1:0] pinRaw, entDestMode, entTrigLevel, entPolarity, entMask;
  logic [7:0]  cfgVec  [NP];
  logic [DW-1:0] cfgDest [NP];
  logic [2:0]  cfgDm   [NP];
  logic [NP*8-1:0]  entVector;
  logic [NP*DW-1:0] entDest;
  logic [NP*3-1:0]  entDelivMode;
  logic tblUpdate, eoiValid, eoiLevel, dlvAccept;
  logic [7:0] eoiVector;
  logic [DW-1:0] bootCpuId;
  logic dlvValid, dlvDestMode, dlvTrigLevel, dlvAssert;
  logic [2:0] dlvPin, dlvDelivMode;
  logic [DW-1:0] dlvDest;
  logic [7:0] dlvVector;
  logic [1:0] dlvShorthand;
  logic [NP-1:0] ackPulse, coalesced, pendingVec, remoteIrrVec;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      entVector[i*8 +: 8]     = cfgVec[i];
      entDest[i*DW +: DW]     = cfgDest[i];
      entDelivMode[i*3 +: 3]  = cfgDm[i];
    end
  end

  trig_eoi_engine #(.NUM_PINS(NP), .DEST_W(DW)) uut (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .entVector(entVector),
    .entDest(entDest), .entDestMode(entDestMode), .entDelivMode(entDelivMode),
    .entTrigLevel(entTrigLevel), .entPolarity(entPolarity), .entMask(entMask),
    .tblUpdate(tblUpdate), .bootCpuId(bootCpuId), .eoiValid(eoiValid),
    .eoiVector(eoiVector), .eoiLevel(eoiLevel), .dlvAccept(dlvAccept),
    .dlvValid(dlvValid), .dlvPin(dlvPin), .dlvDest(dlvDest),
    .dlvVector(dlvVector), .dlvDestMode(dlvDestMode),
    .dlvDelivMode(dlvDelivMode), .dlvTrigLevel(dlvTrigLevel),
    .dlvAssert(dlvAssert), .dlvShorthand(dlvShorthand), .ackPulse(ackPulse),
    .coalesced(coalesced), .pendingVec(pendingVec), .remoteIrrVec(remoteIrrVec)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one rising edge, then settle away from it
  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic logic [NP-1:0] effLevel(input logic [NP-1:0] raw,
                                             input logic [NP-1:0] pol);
    return raw ^ pol;
  endfunction

  function automatic logic [NP-1:0] pinBit(input int p);
    return NP'(1) << p;
  endfunction

  task automatic accept();
    dlvAccept = 1'b1;
    step();
    dlvAccept = 1'b0;
  endtask

  task automatic sendEoi(input logic [7:0] v, input logic lvl);
    eoiValid = 1'b1; eoiVector = v; eoiLevel = lvl;
    step();
    eoiValid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] prevEff;
    rstN = 1'b0; pinRaw = '0; entDestMode = '0; entTrigLevel = '0;
    entPolarity = '0; entMask = '1; tblUpdate = 1'b0; eoiValid = 1'b0;
    eoiLevel = 1'b0; eoiVector = '0; dlvAccept = 1'b0; bootCpuId = 8'h09;
    for (int i = 0; i < NP; i++) begin
      cfgVec[i] = 8'h30 + 8'(i); cfgDest[i] = 8'h80 + 8'(i); cfgDm[i] = 3'd0;
    end
    step(3);
    rstN = 1'b1;
    step();
    chk("R2", "reset pending", pendingVec, 0);
    chk("R4", "reset remote", remoteIrrVec, 0);
    chk("R6", "reset valid", dlvValid, 0);
    chk("R10", "reset ack", ackPulse, 0);

    // R9: map empty before the first table update
    cfgVec[4] = 8'h77; cfgVec[6] = 8'h77;
    sendEoi(8'h77, 1'b1);
    chk("R9", "eoi before map rebuild", ackPulse, 0);
    tblUpdate = 1'b1; step(); tblUpdate = 1'b0;
    sendEoi(8'h77, 1'b0);
    chk("R10", "multi-pin ack", ackPulse, pinBit(4) | pinBit(6));
    step();
    chk("R10", "ack one cycle", ackPulse, 0);

    // R1/R5: active-low masked pin
    entPolarity[5] = 1'b1;
    step();
    chk("R1", "active-low idle pending", pendingVec[5], effLevel(pinRaw, entPolarity) >> 5);
    pinRaw[5] = 1'b1;
    step();
    chk("R1", "active-low driven high", pendingVec[5], 0);
    chk("R5", "masked no delivery", dlvValid, 0);
    entPolarity[5] = 1'b0; pinRaw[5] = 1'b0;
    step();

    // R6/R3: edge pin 3
    cfgVec[3] = 8'h43; cfgDest[3] = 8'h15; entDestMode[3] = 1'b1; cfgDm[3] = 3'd1;
    entMask[3] = 1'b0;
    pinRaw[3] = 1'b1;
    step();
    chk("R2", "pending follows", pendingVec[3], 1);
    chk("R6", "not yet valid", dlvValid, 0);
    step();
    chk("R6", "valid", dlvValid, 1);
    chk("R6", "pin", dlvPin, 3);
    chk("R6", "vector", dlvVector, 8'h43);
    chk("R6", "dest", dlvDest, 8'h15);
    chk("R6", "destmode", dlvDestMode, 1);
    chk("R6", "delivmode", dlvDelivMode, 1);
    chk("R6", "trig", dlvTrigLevel, 0);
    chk("R6", "assert flag", dlvAssert, 1);
    chk("R6", "shorthand", dlvShorthand, 0);
    step(2);
    chk("R6", "held unaccepted", dlvValid, 1);
    chk("R6", "held vector", dlvVector, 8'h43);
    accept();
    chk("R6", "dropped after accept", dlvValid, 0);
    step(3);
    chk("R3", "held level no redelivery", dlvValid, 0);
    pinRaw[3] = 1'b0; step();
    pinRaw[3] = 1'b1; step(2);
    chk("R3", "second edge delivered", dlvValid, 1);
    pinRaw[3] = 1'b0; step();
    pinRaw[3] = 1'b1; step();
    chk("R3", "coalesced pulse", coalesced[3], 1);
    accept();
    step();
    chk("R3", "no extra delivery", dlvValid, 0);
    pinRaw[3] = 1'b0; entMask[3] = 1'b1; step();

    // R4/R10/R11: level pin 2
    cfgVec[2] = 8'h61; entTrigLevel[2] = 1'b1; entMask[2] = 1'b0;
    tblUpdate = 1'b1; step(); tblUpdate = 1'b0;
    pinRaw[2] = 1'b1; step(2);
    chk("R4", "level delivered", dlvValid, 1);
    chk("R4", "level trig field", dlvTrigLevel, 1);
    accept();
    chk("R4", "remote set", remoteIrrVec[2], 1);
    step(3);
    chk("R4", "blocked by remote", dlvValid, 0);
    sendEoi(8'h61, 1'b1);
    chk("R10", "ack pin2", ackPulse, pinBit(2));
    chk("R11", "remote cleared", remoteIrrVec[2], 0);
    step();
    chk("R11", "redelivered", dlvValid, 1);
    accept();
    pinRaw[2] = 1'b0; step();
    pinRaw[2] = 1'b1; step();
    chk("R4", "level coalesced", coalesced[2], 1);
    pinRaw[2] = 1'b0; step();
    sendEoi(8'h61, 1'b0);
    chk("R10", "edge-type ack", ackPulse[2], 1);
    chk("R11", "edge-type keeps remote", remoteIrrVec[2], 1);
    sendEoi(8'h61, 1'b1);
    step();
    chk("R11", "not pending no redelivery", dlvValid, 0);
    entMask[2] = 1'b1;

    // R8: priority
    entMask[1] = 1'b0; entMask[6] = 1'b0;
    pinRaw[1] = 1'b1; pinRaw[6] = 1'b1;
    step(2);
    chk("R8", "lowest first", dlvPin, 1);
    accept();
    chk("R8", "bubble after accept", dlvValid, 0);
    step();
    chk("R8", "second grant", dlvPin, 6);
    chk("R8", "second valid", dlvValid, 1);
    accept();
    pinRaw[1] = 1'b0; pinRaw[6] = 1'b0; entMask[1] = 1'b1; entMask[6] = 1'b1;

    // R7: pin 0 override
    cfgVec[0] = 8'h20; cfgDest[0] = 8'h3C; entDestMode[0] = 1'b1; entMask[0] = 1'b0;
    pinRaw[0] = 1'b1; step(2);
    chk("R7", "pin0 destmode", dlvDestMode, 0);
    chk("R7", "pin0 dest", dlvDest, 8'h09);
    chk("R7", "pin0 vector", dlvVector, 8'h20);
    accept();
    pinRaw[0] = 1'b0; entMask[0] = 1'b1; step(2);

    // random: all masked, R1/R2/R5
    void'($urandom(32'h1234_5678));
    prevEff = effLevel(pinRaw, entPolarity);
    for (int c = 0; c < 300; c++) begin
      pinRaw = NP'($urandom);
      entPolarity = NP'($urandom);
      prevEff = effLevel(pinRaw, entPolarity);
      step();
      chk("R2", "random pending", pendingVec, prevEff);
      chk("R5", "random masked", dlvValid, 0);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule